// File: doc/BRIEF.md
# SMT-Partitioned Return Address Predictor

This block predicts return targets for two hardware threads that share one core. Every call pushes its return address onto the stack of the calling thread. Every return pops the top entry, and that entry is the prediction. The storage is one array of `2*HALF` entries.

While both threads run (dual mode), each thread owns a private half. Thread 0 uses entries `0..HALF-1` and thread 1 uses `HALF..2*HALF-1`, and each half has a circular offset pointer. When one thread leaves the running power state, the core drops to solo mode. The remaining thread then owns a single merged stack of `2*HALF` entries with one wider circular pointer.

A mode switch never touches the stored entries. Only the pointers are remapped. As a result, a thread that just became sole owner can pop entries that its sibling wrote. An optional scrub fills every entry with a configurable safe target after each switch, and predictions are held invalid until the fill has finished.

Top module: `smt_ras_top`

## Requirements
- R1: After reset, both prediction valid flags are 0, `one_thread_mode` is 0 (dual) and `scrub_busy` is 0.
- R2: In dual mode, a push from thread t makes `pred_tgt<t>` equal to the pushed target with `pred_vld<t>`=1 on the next cycle. The other thread's prediction is unchanged.
- R3: A pop returns the stack to the previous entry (last in, first out). A pop on an empty stack has no effect: the stack stays invalid and a later push is seen alone.
- R4: In dual mode, when exactly one of `c0_act0`/`c0_act1` is 1, the block enters solo mode and `active_owner` becomes the index of the active thread. In solo mode, when both are 1, it returns to dual mode. Pushes and pops in the switch cycle are dropped. In solo mode, operations from the non-owner are ignored and its valid flag is 0.
- R5: On entering solo mode, the merged pointer becomes `{owner, owner_offset}`, that is, region base plus offset. The merged count becomes the sum of both thread counts, saturated at 2*HALF.
- R6: Entries persist across switches. In solo mode, pops that move below the owner's region base predict entries from the sibling's region.
- R7: On returning to dual mode, the owner's offset becomes the low PW bits of the merged pointer, and its count becomes min(merged count, HALF). The idle thread's offset and count are unchanged.
- R8: A push and a pop from the same thread in the same cycle overwrite the top entry in place. The pointer and count do not change.
- R9: Counts saturate at the current capacity (HALF in dual mode). Pushes beyond it overwrite the oldest entries circularly, and HALF pops then empty the stack.
- R10: With `scrub_en`=1, every mode switch sets `scrub_busy` for 2*HALF cycles while `safe_tgt` is written into every entry. While the scrub runs, both valid flags are 0 and pushes and pops are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| c0_act0 | input | 1 | Thread 0 is in the running power state |
| call0 | input | 1 | Thread 0 call (push) |
| call_tgt0 | input | TW | Thread 0 return target to push |
| ret0 | input | 1 | Thread 0 return (pop) |
| c0_act1 | input | 1 | Thread 1 is in the running power state |
| call1 | input | 1 | Thread 1 call (push) |
| call_tgt1 | input | TW | Thread 1 return target to push |
| ret1 | input | 1 | Thread 1 return (pop) |
| scrub_en | input | 1 | Fill the array with the safe target on every mode switch |
| safe_tgt | input | TW | Target written by the scrub |
| pred_tgt0 | output | TW | Predicted return target, thread 0 |
| pred_vld0 | output | 1 | Thread 0 prediction valid |
| pred_tgt1 | output | TW | Predicted return target, thread 1 |
| pred_vld1 | output | 1 | Thread 1 prediction valid |
| one_thread_mode | output | 1 | 1 = solo mode, 0 = dual mode |
| active_owner | output | 1 | Owning thread index in solo mode |
| scrub_busy | output | 1 | Scrub fill in progress |

## Verification
Two pairs of functions can coincide in one cycle, and both are provoked on purpose. The first pair is a call and a return from the same thread. The bench drives both in one cycle and expects the new target on top with the depth unchanged, so that a single later pop empties the stack. The second pair is a mode switch and a push. The bench drops a thread's activity while the sibling pushes, and expects the prediction to still show the previous entry. After scrub-triggering switches, a push issued while the fill runs is judged by counting how many pops it takes to empty the stack.

// File: rtl/smt_ras_pkg.sv
package smt_ras_pkg;

  typedef enum logic {
    MODE_DUAL = 1'b0,
    MODE_SOLO = 1'b1
  } ras_mode_e;

endpackage

// File: rtl/smt_ras_mode.sv
module smt_ras_mode
  import smt_ras_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic act0,
  input  logic act1,
  output logic solo_o,
  output logic owner_o,
  output logic enter_solo_o,
  output logic leave_solo_o,
  output logic next_owner_o
);

  ras_mode_e mode_q;
  logic      owner_q;

  always_comb begin
    enter_solo_o = (mode_q == MODE_DUAL) && (act0 ^ act1);
    leave_solo_o = (mode_q == MODE_SOLO) && act0 && act1;
    next_owner_o = act1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_DUAL;
      owner_q <= 1'b0;
    end else if (enter_solo_o) begin
      mode_q  <= MODE_SOLO;
      owner_q <= next_owner_o;
    end else if (leave_solo_o) begin
      mode_q  <= MODE_DUAL;
    end
  end

  assign solo_o  = (mode_q == MODE_SOLO);
  assign owner_o = owner_q;

endmodule

// File: rtl/smt_ras_scrub.sv
module smt_ras_scrub #(
  parameter int unsigned DEPTH = 32,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  output logic          busy_o,
  output logic          we_o,
  output logic [IW-1:0] idx_o
);

  localparam logic [IW-1:0] LAST = IW'(DEPTH - 1);

  logic          busy_q;
  logic [IW-1:0] idx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      idx_q  <= '0;
    end else if (busy_q) begin
      if (idx_q == LAST) busy_q <= 1'b0;
      else               idx_q  <= idx_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign we_o   = busy_q;
  assign idx_o  = idx_q;

endmodule

// File: rtl/smt_ras_top.sv
module smt_ras_top
  import smt_ras_pkg::*;
#(
  parameter int unsigned HALF = 16,
  parameter int unsigned TW   = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          c0_act0,
  input  logic          call0,
  input  logic [TW-1:0] call_tgt0,
  input  logic          ret0,
  input  logic          c0_act1,
  input  logic          call1,
  input  logic [TW-1:0] call_tgt1,
  input  logic          ret1,
  input  logic          scrub_en,
  input  logic [TW-1:0] safe_tgt,
  output logic [TW-1:0] pred_tgt0,
  output logic          pred_vld0,
  output logic [TW-1:0] pred_tgt1,
  output logic          pred_vld1,
  output logic          one_thread_mode,
  output logic          active_owner,
  output logic          scrub_busy
);

  localparam int unsigned TOTAL = 2 * HALF;
  localparam int unsigned PW    = $clog2(HALF);
  localparam int unsigned MW    = PW + 1;
  localparam int unsigned CW    = $clog2(TOTAL + 1);

  // ---- arithmetic helpers ----
  function automatic logic [MW-1:0] region_addr(input logic th, input logic [PW-1:0] off);
    return {th, off};
  endfunction

  function automatic logic [CW-1:0] cnt_up(input logic [CW-1:0] c, input logic [CW-1:0] cap);
    return (c >= cap) ? cap : c + 1'b1;
  endfunction

  function automatic logic [CW-1:0] cnt_down(input logic [CW-1:0] c);
    return (c == '0) ? c : c - 1'b1;
  endfunction

  function automatic logic [CW-1:0] merge_cnt(input logic [CW-1:0] a, input logic [CW-1:0] b);
    logic [CW:0] s;
    s = {1'b0, a} + {1'b0, b};
    return (s > (CW+1)'(TOTAL)) ? CW'(TOTAL) : s[CW-1:0];
  endfunction

  function automatic logic [CW-1:0] split_cnt(input logic [CW-1:0] m);
    return (m > CW'(HALF)) ? CW'(HALF) : m;
  endfunction

  // ---- mode control ----
  logic solo, owner, enter_solo, leave_solo, next_owner, mode_switch;

  smt_ras_mode u_mode (
    .clk          (clk),
    .rst_n        (rst_n),
    .act0         (c0_act0),
    .act1         (c0_act1),
    .solo_o       (solo),
    .owner_o      (owner),
    .enter_solo_o (enter_solo),
    .leave_solo_o (leave_solo),
    .next_owner_o (next_owner)
  );

  assign mode_switch = enter_solo | leave_solo;

  // ---- scrub sequencer ----
  logic          scrub_start, scrub_busy_w, scrub_we;
  logic [MW-1:0] scrub_idx;

  assign scrub_start = mode_switch & scrub_en;

  smt_ras_scrub #(.DEPTH(TOTAL)) u_scrub (
    .clk     (clk),
    .rst_n   (rst_n),
    .start_i (scrub_start),
    .busy_o  (scrub_busy_w),
    .we_o    (scrub_we),
    .idx_o   (scrub_idx)
  );

  // ---- operation decode ----
  logic          accept;
  logic [1:0]    push_v, pop_v, dual_push, dual_pop;
  logic [TW-1:0] tgt_v [2];
  logic          solo_push, solo_pop;
  logic [TW-1:0] solo_tgt;

  assign accept   = !scrub_busy_w && !mode_switch;
  assign push_v   = {call1, call0};
  assign pop_v    = {ret1, ret0};
  assign tgt_v[0] = call_tgt0;
  assign tgt_v[1] = call_tgt1;

  assign dual_push = (accept && !solo) ? push_v : 2'b00;
  assign dual_pop  = (accept && !solo) ? pop_v  : 2'b00;
  assign solo_push = accept && solo && push_v[owner];
  assign solo_pop  = accept && solo && pop_v[owner];
  assign solo_tgt  = tgt_v[owner];

  // ---- state ----
  logic [PW-1:0] ptr_q [2];
  logic [CW-1:0] cnt_q [2];
  logic [MW-1:0] mptr_q;
  logic [CW-1:0] mcnt_q;
  logic [TW-1:0] mem_q [TOTAL];

  // ---- write ports ----
  logic [1:0]    wr_en;
  logic [MW-1:0] wr_addr [2];
  logic [TW-1:0] wr_data [2];

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      wr_en[t]   = dual_push[t];
      wr_data[t] = tgt_v[t];
      wr_addr[t] = dual_pop[t] ? region_addr(1'(t), ptr_q[t] - 1'b1)
                               : region_addr(1'(t), ptr_q[t]);
    end
    if (solo_push) begin
      wr_en[0]   = 1'b1;
      wr_data[0] = solo_tgt;
      wr_addr[0] = solo_pop ? mptr_q - 1'b1 : mptr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < int'(TOTAL); i++) mem_q[i] <= '0;
    end else begin
      for (int i = 0; i < int'(TOTAL); i++) begin
        if (scrub_we && scrub_idx == MW'(i))         mem_q[i] <= safe_tgt;
        else if (wr_en[0] && wr_addr[0] == MW'(i))   mem_q[i] <= wr_data[0];
        else if (wr_en[1] && wr_addr[1] == MW'(i))   mem_q[i] <= wr_data[1];
      end
    end
  end

  // ---- pointers and counts ----
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int t = 0; t < 2; t++) begin
        ptr_q[t] <= '0;
        cnt_q[t] <= '0;
      end
      mptr_q <= '0;
      mcnt_q <= '0;
    end else begin
      if (enter_solo) begin
        mptr_q <= region_addr(next_owner, ptr_q[next_owner]);
        mcnt_q <= merge_cnt(cnt_q[0], cnt_q[1]);
      end
      if (leave_solo) begin
        ptr_q[owner] <= mptr_q[PW-1:0];
        cnt_q[owner] <= split_cnt(mcnt_q);
      end
      for (int t = 0; t < 2; t++) begin
        if (dual_push[t] && !dual_pop[t]) begin
          ptr_q[t] <= ptr_q[t] + 1'b1;
          cnt_q[t] <= cnt_up(cnt_q[t], CW'(HALF));
        end else if (dual_pop[t] && !dual_push[t] && cnt_q[t] != '0) begin
          ptr_q[t] <= ptr_q[t] - 1'b1;
          cnt_q[t] <= cnt_down(cnt_q[t]);
        end
      end
      if (solo_push && !solo_pop) begin
        mptr_q <= mptr_q + 1'b1;
        mcnt_q <= cnt_up(mcnt_q, CW'(TOTAL));
      end else if (solo_pop && !solo_push && mcnt_q != '0) begin
        mptr_q <= mptr_q - 1'b1;
        mcnt_q <= cnt_down(mcnt_q);
      end
    end
  end

  // ---- prediction read ----
  logic [TW-1:0] pred_t [2];
  logic [1:0]    pred_v;
  logic [MW-1:0] mtop;

  assign mtop = mptr_q - 1'b1;

  always_comb begin
    for (int t = 0; t < 2; t++) begin
      if (solo) begin
        pred_t[t] = (owner == 1'(t)) ? mem_q[mtop] : '0;
        pred_v[t] = (owner == 1'(t)) && (mcnt_q != '0) && !scrub_busy_w;
      end else begin
        pred_t[t] = mem_q[region_addr(1'(t), ptr_q[t] - 1'b1)];
        pred_v[t] = (cnt_q[t] != '0) && !scrub_busy_w;
      end
    end
  end

  assign pred_tgt0       = pred_t[0];
  assign pred_vld0       = pred_v[0];
  assign pred_tgt1       = pred_t[1];
  assign pred_vld1       = pred_v[1];
  assign one_thread_mode = solo;
  assign active_owner    = owner;
  assign scrub_busy      = scrub_busy_w;

endmodule

// File: rtl/smt_ras_checker.sv
module smt_ras_checker #(
  parameter int unsigned TW    = 32,
  parameter int unsigned TOTAL = 32,
  localparam int unsigned IW   = $clog2(TOTAL)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          c0_act0,
  input logic          c0_act1,
  input logic          call0,
  input logic          ret0,
  input logic [TW-1:0] call_tgt0,
  input logic [TW-1:0] pred_tgt0,
  input logic          pred_vld0,
  input logic          one_thread_mode,
  input logic          active_owner,
  input logic          scrub_busy,
  input logic          scrub_en,
  input logic          mode_switch,
  input logic [IW-1:0] scrub_idx
);

  // R2: a lone dual-mode push by thread 0 is on top next cycle
  p_push_visible_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!one_thread_mode && !scrub_busy && !mode_switch && call0 && !ret0)
      |=> (pred_vld0 && pred_tgt0 == $past(call_tgt0)));

  // R3: a pop on an empty thread-0 stack keeps it empty
  p_empty_pop_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!one_thread_mode && !scrub_busy && !mode_switch && ret0 && !call0 && !pred_vld0)
      |=> !pred_vld0);

  // R4: one thread leaving the running state enters solo mode
  p_enter_solo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!one_thread_mode && (c0_act0 ^ c0_act1)) |=> (one_thread_mode && active_owner == $past(c0_act1)));

  // R4: both threads running again returns to dual mode
  p_leave_solo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (one_thread_mode && c0_act0 && c0_act1) |=> !one_thread_mode);

  // R4: owner holds while solo mode persists
  p_owner_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (one_thread_mode && !(c0_act0 && c0_act1)) |=> (one_thread_mode && $stable(active_owner)));

  // R10: a switch with scrub enabled starts the fill
  p_scrub_start_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_switch && scrub_en) |=> scrub_busy);

  // R10: the fill ends only after the last entry
  p_scrub_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scrub_busy) |-> ($past(scrub_idx) == IW'(TOTAL - 1)));

endmodule

bind smt_ras_top smt_ras_checker #(.TW(TW), .TOTAL(2 * HALF)) u_chk (
  .clk             (clk),
  .rst_n           (rst_n),
  .c0_act0         (c0_act0),
  .c0_act1         (c0_act1),
  .call0           (call0),
  .ret0            (ret0),
  .call_tgt0       (call_tgt0),
  .pred_tgt0       (pred_tgt0),
  .pred_vld0       (pred_vld0),
  .one_thread_mode (one_thread_mode),
  .active_owner    (active_owner),
  .scrub_busy      (scrub_busy),
  .scrub_en        (scrub_en),
  .mode_switch     (mode_switch),
  .scrub_idx       (scrub_idx)
);

// File: tb/smt_ras_top_test.sv
`timescale 1ns/1ps
module smt_ras_top_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        c0_act0 = 1'b1, c0_act1 = 1'b1;
  logic        call0 = 1'b0, ret0 = 1'b0, call1 = 1'b0, ret1 = 1'b0;
  logic [31:0] call_tgt0 = '0, call_tgt1 = '0;
  logic        scrub_en = 1'b0;
  logic [31:0] safe_tgt = 32'h5AFE_5AFE;
  logic [31:0] pred_tgt0, pred_tgt1;
  logic        pred_vld0, pred_vld1, one_thread_mode, active_owner, scrub_busy;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  smt_ras_top uut (
    .clk(clk), .rst_n(rst_n),
    .c0_act0(c0_act0), .call0(call0), .call_tgt0(call_tgt0), .ret0(ret0),
    .c0_act1(c0_act1), .call1(call1), .call_tgt1(call_tgt1), .ret1(ret1),
    .scrub_en(scrub_en), .safe_tgt(safe_tgt),
    .pred_tgt0(pred_tgt0), .pred_vld0(pred_vld0),
    .pred_tgt1(pred_tgt1), .pred_vld1(pred_vld1),
    .one_thread_mode(one_thread_mode), .active_owner(active_owner),
    .scrub_busy(scrub_busy)
  );

  typedef struct {
    string       req;
    bit          v0;
    logic [31:0] t0;
    bit          v1;
    logic [31:0] t1;
    bit          solo;
    bit          own;
    bit          busy;
  } exp_t;

  exp_t exp_q[$];
  exp_t e;

  // monitor: compares one queued expectation per falling edge
  always @(negedge clk) begin
    if (exp_q.size() != 0) begin
      bit ok;
      e = exp_q.pop_front();
      checks++;
      ok = (one_thread_mode == e.solo) && (scrub_busy == e.busy) &&
           (!e.solo || active_owner == e.own) &&
           (pred_vld0 == e.v0) && (!e.v0 || pred_tgt0 == e.t0) &&
           (pred_vld1 == e.v1) && (!e.v1 || pred_tgt1 == e.t1);
      if (!ok) begin
        fails++;
        $display("FAIL %s: got solo=%0b own=%0b busy=%0b v0=%0b t0=%h v1=%0b t1=%h expected solo=%0b own=%0b busy=%0b v0=%0b t0=%h v1=%0b t1=%h",
                 e.req, one_thread_mode, active_owner, scrub_busy, pred_vld0, pred_tgt0,
                 pred_vld1, pred_tgt1, e.solo, e.own, e.busy, e.v0, e.t0, e.v1, e.t1);
      end
    end
  end

  task automatic cyc(input bit a0, input bit a1,
                     input bit p0, input logic [31:0] d0, input bit r0,
                     input bit p1, input logic [31:0] d1, input bit r1);
    @(negedge clk);
    c0_act0 = a0; c0_act1 = a1;
    call0 = p0; call_tgt0 = d0; ret0 = r0;
    call1 = p1; call_tgt1 = d1; ret1 = r1;
    @(posedge clk);
    #1;
    call0 = 1'b0; ret0 = 1'b0; call1 = 1'b0; ret1 = 1'b0;
  endtask

  task automatic expect_out(input string req, input bit v0, input logic [31:0] t0,
                            input bit v1, input logic [31:0] t1,
                            input bit solo, input bit own, input bit busy);
    exp_t x;
    x.req = req; x.v0 = v0; x.t0 = t0; x.v1 = v1; x.t1 = t1;
    x.solo = solo; x.own = own; x.busy = busy;
    exp_q.push_back(x);
  endtask

  task automatic do_reset(input bit scrub);
    @(negedge clk);
    rst_n = 1'b0; c0_act0 = 1'b1; c0_act1 = 1'b1; scrub_en = scrub;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk);
    #1;
  endtask

  task automatic summary;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      summary();
      $finish;
    end
  end

  initial begin
    // ---- R1 reset state ----
    do_reset(1'b0);
    expect_out("R1 reset", 0, 0, 0, 0, 0, 0, 0);

    // ---- dual mode private stacks ----
    cyc(1,1, 1,32'hA001,0, 1,32'hB001,0);
    expect_out("R2 both push", 1, 32'hA001, 1, 32'hB001, 0, 0, 0);
    cyc(1,1, 1,32'hA002,0, 0,0,0);
    expect_out("R2 t0 push only", 1, 32'hA002, 1, 32'hB001, 0, 0, 0);
    cyc(1,1, 0,0,1, 0,0,0);
    expect_out("R3 pop lifo", 1, 32'hA001, 1, 32'hB001, 0, 0, 0);
    cyc(1,1, 0,0,0, 1,32'hB009,1);
    expect_out("R8 replace top", 1, 32'hA001, 1, 32'hB009, 0, 0, 0);
    cyc(1,1, 0,0,0, 0,0,1);
    expect_out("R8 depth unchanged", 1, 32'hA001, 0, 0, 0, 0, 0);
    cyc(1,1, 0,0,0, 0,0,1);
    expect_out("R3 empty pop", 1, 32'hA001, 0, 0, 0, 0, 0);
    cyc(1,1, 0,0,0, 1,32'hB002,0);
    expect_out("R3 push after empty pop", 1, 32'hA001, 1, 32'hB002, 0, 0, 0);
    cyc(1,1, 0,0,0, 0,0,1);
    expect_out("R3 single pop empties", 1, 32'hA001, 0, 0, 0, 0, 0);

    // ---- R9 saturation and circular overwrite ----
    for (int i = 0; i < 16; i++) begin
      cyc(1,1, 1,32'hC000 + 32'(i),0, 0,0,0);
      expect_out("R9 push", 1, 32'hC000 + 32'(i), 0, 0, 0, 0, 0);
    end
    for (int k = 1; k <= 16; k++) begin
      cyc(1,1, 0,0,1, 0,0,0);
      if (k < 16) expect_out("R9 pop", 1, 32'hC000 + 32'(15 - k), 0, 0, 0, 0, 0);
      else        expect_out("R9 empty after capacity pops", 0, 0, 0, 0, 0, 0, 0);
    end

    // ---- R4 R5 R6 R7 remap and cross-thread reads ----
    do_reset(1'b0);
    cyc(1,1, 1,32'hD000,0, 1,32'hE000,0);
    for (int i = 1; i < 16; i++) cyc(1,1, 1,32'hD000 + 32'(i),0, 0,0,0);
    expect_out("R2 fill", 1, 32'hD00F, 1, 32'hE000, 0, 0, 0);
    cyc(0,1, 0,0,0, 1,32'h9999,0);
    expect_out("R4 R5 enter solo, push dropped", 0, 0, 1, 32'hE000, 1, 1, 0);
    cyc(0,1, 0,0,0, 0,0,1);
    expect_out("R6 pop reads sibling", 0, 0, 1, 32'hD00F, 1, 1, 0);
    cyc(0,1, 0,0,0, 0,0,1);
    expect_out("R6 second sibling read", 0, 0, 1, 32'hD00E, 1, 1, 0);
    cyc(0,1, 1,32'hF00F,0, 1,32'h5151,0);
    expect_out("R4 idle thread ignored", 0, 0, 1, 32'h5151, 1, 1, 0);
    cyc(1,1, 0,0,0, 0,0,0);
    expect_out("R7 back to dual", 1, 32'h5151, 1, 32'h0, 0, 0, 0);

    // ---- R10 scrub on switch ----
    do_reset(1'b1);
    cyc(1,1, 1,32'hAA01,0, 1,32'hBB01,0);
    expect_out("R10 pre-scrub", 1, 32'hAA01, 1, 32'hBB01, 0, 0, 0);
    cyc(1,0, 0,0,0, 0,0,0);
    expect_out("R10 busy after switch", 0, 0, 0, 0, 1, 0, 1);
    cyc(1,0, 1,32'hCC01,0, 0,0,0);
    expect_out("R10 push during busy", 0, 0, 0, 0, 1, 0, 1);
    for (int i = 0; i < 30; i++) begin
      cyc(1,0, 0,0,0, 0,0,0);
      expect_out("R10 still busy", 0, 0, 0, 0, 1, 0, 1);
    end
    cyc(1,0, 0,0,0, 0,0,0);
    expect_out("R10 scrub done", 1, 32'h5AFE_5AFE, 0, 0, 1, 0, 0);
    cyc(1,0, 0,0,1, 0,0,0);
    expect_out("R10 safe below top", 1, 32'h5AFE_5AFE, 0, 0, 1, 0, 0);
    cyc(1,0, 0,0,1, 0,0,0);
    expect_out("R10 busy push ignored", 0, 0, 0, 0, 1, 0, 0);
    cyc(1,1, 0,0,0, 0,0,0);
    expect_out("R10 scrub on leave", 0, 0, 0, 0, 0, 0, 1);

    cyc(1,1, 0,0,0, 0,0,0);
    done = 1'b1;
    summary();
    $finish;
  end

endmodule